// File: doc/BRIEF.md
# Pointer-Addressed Two-Wire Register Slave

This block is the slave side of a two-wire serial bus (SCL clock, SDA open-drain data) sitting in front of six 16-bit registers. A fast system clock oversamples both bus lines. The block finds START and STOP conditions, compares the 7-bit device address with its own, and acknowledges the bytes it accepts. It keeps a write-only pointer that picks which register later data bytes reach. Each 16-bit register moves as two bytes, the high byte first.

A bus master normally writes the address and a pointer byte. It may then write a 16-bit word, or issue a repeated START and read back the selected register. Four of the registers are writable settings, and their contents appear on output ports. One register is a fixed capability word. One reflects a live 16-bit measurement input. Clock stretching, arbitration and analog glitch filtering are not part of the block.

Top module: `ptr_serial_regif`

## Requirements
- R1: After a synchronous reset, `sda_pull` is 0 and the four writable registers hold 0x0000. The pointer holds 000, so a read with no pointer write returns 0x0001.
- R2: The device address is the binary prefix 0011 followed by `strap[2]`, `strap[1]`, `strap[0]`, and then the read/write bit (1 means read). A matching address is acknowledged by holding SDA low during the ninth clock. A mismatching address gets no acknowledge, and the rest of that transaction has no effect.
- R3: START is SDA falling while SCL is high. STOP is SDA rising while SCL is high. A START at any point, including a repeated START in the middle of a transaction, restarts the address phase. After a START or a STOP the block releases SDA.
- R4: In a write transaction the first byte after the address loads the pointer from its bits [2:0]. Bits [7:3] are ignored. The pointer keeps its value across transactions until the next pointer write.
- R5: Pointer codes select registers as follows: 000 capability (fixed 0x0001), 001 configuration, 010 upper limit, 011 lower limit, 100 critical limit, 101 temperature (reads the `temp_value` input).
- R6: When a pointer byte is followed by two data bytes, the first data byte is bits [15:8] and the second is bits [7:0]. The selected writable register takes the word when the second byte completes, and it appears on its output port.
- R7: A write transaction that ends after only one data byte leaves every register unchanged.
- R8: Writes to codes 000, 101, 110 and 111 are acknowledged and change nothing.
- R9: A read transaction returns the selected register high byte first, then the low byte. If the master acknowledges the low byte, the register is fetched again and its high byte follows. A master NACK ends the transfer. Codes 110 and 111 read as 0x0000.
- R10: The block pulls SDA low only in its acknowledge slots and for 0 bits of read data. The pull changes only while SCL is low.
- R11: Data bytes after the second one in a write are acknowledged and ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| sda_pull | output | 1 | 1 pulls SDA low (open-drain enable) |
| strap | input | 3 | Low three device address bits |
| temp_value | input | 16 | Live measurement returned by code 101 |
| config_q | output | 16 | Configuration register contents |
| upper_q | output | 16 | Upper limit register contents |
| lower_q | output | 16 | Lower limit register contents |
| critical_q | output | 16 | Critical limit register contents |

## Verification
A wrong pointer or wrong phase inside the block shows up at the ports within one byte time. The acknowledge bit goes missing or appears, a read byte comes back from the wrong register, or a register output changes when it should hold. A bad bit counter misplaces the SDA pull by one SCL period. This corrupts the next read byte or acknowledge, and the register outputs are compared against a model on every clock while the bus is idle. A write applied to the wrong register or at the wrong moment is seen on the output ports before the next transaction begins.

// File: rtl/psr_pkg.sv
package psr_pkg;

  localparam int BYTE_W = 8;

  // register select codes carried in the pointer
  typedef enum logic [2:0] {
    SEL_CAPS   = 3'd0,
    SEL_CONFIG = 3'd1,
    SEL_HI_LIM = 3'd2,
    SEL_LO_LIM = 3'd3,
    SEL_CRIT   = 3'd4,
    SEL_TEMP   = 3'd5
  } reg_sel_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RECV,
    ST_ACK,
    ST_SEND,
    ST_MACK
  } link_state_e;

  typedef enum logic [2:0] {
    PH_ADDR,
    PH_PTR,
    PH_HI,
    PH_LO,
    PH_SPILL
  } byte_phase_e;

endpackage

// File: rtl/psr_line_sync.sv
module psr_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_pin,
  input  logic sda_pin,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_p,
  output logic stop_p
);

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_prev;
  logic              sda_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_pin};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_pin};
      scl_prev <= scl_pipe[STAGES-1];
      sda_prev <= sda_pipe[STAGES-1];
    end
  end

  assign scl_lvl  = scl_pipe[STAGES-1];
  assign sda_lvl  = sda_pipe[STAGES-1];
  assign scl_rise = scl_lvl & ~scl_prev;
  assign scl_fall = ~scl_lvl & scl_prev;
  // data edges while the clock stays high mark bus conditions
  assign start_p  = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
  assign stop_p   = scl_lvl & scl_prev & ~sda_prev & sda_lvl;

endmodule

// File: rtl/psr_byte_engine.sv
module psr_byte_engine
  import psr_pkg::*;
#(
  parameter int          REG_W     = 16,
  parameter int          PTR_W     = 3,
  parameter int          STRAP_W   = 3,
  parameter int          BASE_W    = 4,
  parameter logic [3:0]  BASE_ADDR = 4'b0011
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               sda_lvl,
  input  logic               start_p,
  input  logic               stop_p,
  input  logic [STRAP_W-1:0] strap,
  input  logic [REG_W-1:0]   rd_data,
  output logic [PTR_W-1:0]   ptr,
  output logic               wr_en,
  output logic [PTR_W-1:0]   wr_addr,
  output logic [REG_W-1:0]   wr_data,
  output logic               sda_pull
);

  localparam int          ADDR_W = BASE_W + STRAP_W;
  localparam logic [3:0]  BITS   = 4'(BYTE_W);

  link_state_e            st;
  byte_phase_e            ph;
  logic [3:0]             cnt;
  logic [BYTE_W-1:0]      rx;
  logic [BYTE_W-1:0]      hi_q;
  logic [REG_W-1:0]       tx_word;
  logic                   tx_low;
  logic                   is_read;
  logic                   m_ack;
  logic [PTR_W-1:0]       ptr_q;
  logic [ADDR_W-1:0]      dev_addr;
  logic [BYTE_W-1:0]      cur_byte;
  logic [2:0]             bit_idx;

  assign dev_addr = {BASE_ADDR[BASE_W-1:0], strap};
  assign cur_byte = tx_low ? tx_word[BYTE_W-1:0] : tx_word[REG_W-1:REG_W-BYTE_W];
  assign bit_idx  = 3'(4'd7 - cnt);
  assign ptr      = ptr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      ph       <= PH_ADDR;
      cnt      <= '0;
      rx       <= '0;
      hi_q     <= '0;
      tx_word  <= '0;
      tx_low   <= 1'b0;
      is_read  <= 1'b0;
      m_ack    <= 1'b0;
      ptr_q    <= '0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      sda_pull <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (start_p) begin
        st       <= ST_RECV;
        ph       <= PH_ADDR;
        cnt      <= '0;
        sda_pull <= 1'b0;
      end else if (stop_p) begin
        st       <= ST_IDLE;
        sda_pull <= 1'b0;
      end else begin
        unique case (st)
          ST_RECV: begin
            if (scl_rise && cnt < BITS) begin
              rx  <= {rx[BYTE_W-2:0], sda_lvl};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == BITS) begin
              cnt      <= '0;
              st       <= ST_ACK;
              sda_pull <= 1'b1;
              case (ph)
                PH_ADDR: begin
                  if (rx[BYTE_W-1:1] != dev_addr) begin
                    st       <= ST_IDLE;
                    sda_pull <= 1'b0;
                  end else begin
                    is_read <= rx[0];
                    ph      <= PH_PTR;
                  end
                end
                PH_PTR: begin
                  ptr_q <= rx[PTR_W-1:0];
                  ph    <= PH_HI;
                end
                PH_HI: begin
                  hi_q <= rx;
                  ph   <= PH_LO;
                end
                PH_LO: begin
                  wr_en   <= 1'b1;
                  wr_addr <= ptr_q;
                  wr_data <= {hi_q, rx};
                  ph      <= PH_SPILL;
                end
                default: ;
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (is_read) begin
                st       <= ST_SEND;
                tx_word  <= rd_data;
                tx_low   <= 1'b0;
                sda_pull <= ~rd_data[REG_W-1];
              end else begin
                st       <= ST_RECV;
                sda_pull <= 1'b0;
              end
            end
          end
          ST_SEND: begin
            if (scl_rise) begin
              cnt <= cnt + 4'd1;
            end else if (scl_fall) begin
              if (cnt == BITS) begin
                sda_pull <= 1'b0;
                st       <= ST_MACK;
              end else begin
                sda_pull <= ~cur_byte[bit_idx];
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              m_ack <= ~sda_lvl;
            end else if (scl_fall) begin
              if (m_ack) begin
                st  <= ST_SEND;
                cnt <= '0;
                if (tx_low) begin
                  tx_word  <= rd_data;
                  tx_low   <= 1'b0;
                  sda_pull <= ~rd_data[REG_W-1];
                end else begin
                  tx_low   <= 1'b1;
                  sda_pull <= ~tx_word[BYTE_W-1];
                end
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/psr_reg_bank.sv
module psr_reg_bank
  import psr_pkg::*;
#(
  parameter int              REG_W     = 16,
  parameter int              PTR_W     = 3,
  parameter int              NUM_RW    = 4,
  parameter logic [15:0]     CAPS_WORD = 16'h0001
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] wr_addr,
  input  logic [REG_W-1:0] wr_data,
  input  logic [PTR_W-1:0] rd_addr,
  input  logic [REG_W-1:0] temp_value,
  output logic [REG_W-1:0] rd_data,
  output logic [REG_W-1:0] config_q,
  output logic [REG_W-1:0] upper_q,
  output logic [REG_W-1:0] lower_q,
  output logic [REG_W-1:0] critical_q
);

  logic [NUM_RW-1:0][REG_W-1:0] rw_vec;

  // writable registers occupy codes 1 .. NUM_RW
  for (genvar g = 0; g < NUM_RW; g++) begin : g_rw
    logic [REG_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst) begin
        q <= '0;
      end else if (wr_en && wr_addr == PTR_W'(g + 1)) begin
        q <= wr_data;
      end
    end
    assign rw_vec[g] = q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (rd_addr)
        SEL_CAPS:   rd_data <= REG_W'(CAPS_WORD);
        SEL_CONFIG: rd_data <= rw_vec[0];
        SEL_HI_LIM: rd_data <= rw_vec[1];
        SEL_LO_LIM: rd_data <= rw_vec[2];
        SEL_CRIT:   rd_data <= rw_vec[3];
        SEL_TEMP:   rd_data <= temp_value;
        default:    rd_data <= '0;
      endcase
    end
  end

  assign config_q   = rw_vec[0];
  assign upper_q    = rw_vec[1];
  assign lower_q    = rw_vec[2];
  assign critical_q = rw_vec[3];

endmodule

// File: rtl/ptr_serial_regif.sv
module ptr_serial_regif #(
  parameter int          REG_W     = 16,
  parameter int          PTR_W     = 3,
  parameter int          STRAP_W   = 3,
  parameter int          SYNC_LEN  = 2,
  parameter logic [3:0]  BASE_ADDR = 4'b0011,
  parameter logic [15:0] CAPS_WORD = 16'h0001
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_in,
  input  logic               sda_in,
  output logic               sda_pull,
  input  logic [STRAP_W-1:0] strap,
  input  logic [REG_W-1:0]   temp_value,
  output logic [REG_W-1:0]   config_q,
  output logic [REG_W-1:0]   upper_q,
  output logic [REG_W-1:0]   lower_q,
  output logic [REG_W-1:0]   critical_q
);

  localparam int NUM_RW = 4;

  logic             scl_s;
  logic             sda_s;
  logic             scl_rise;
  logic             scl_fall;
  logic             start_p;
  logic             stop_p;
  logic [PTR_W-1:0] ptr;
  logic             wr_en;
  logic [PTR_W-1:0] wr_addr;
  logic [REG_W-1:0] wr_data;
  logic [REG_W-1:0] rd_data;

  psr_line_sync #(
    .STAGES (SYNC_LEN)
  ) u_sync (
    .clk      (clk),
    .rst      (rst),
    .scl_pin  (scl_in),
    .sda_pin  (sda_in),
    .scl_lvl  (scl_s),
    .sda_lvl  (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_p  (start_p),
    .stop_p   (stop_p)
  );

  psr_byte_engine #(
    .REG_W     (REG_W),
    .PTR_W     (PTR_W),
    .STRAP_W   (STRAP_W),
    .BASE_W    (4),
    .BASE_ADDR (BASE_ADDR)
  ) u_engine (
    .clk      (clk),
    .rst      (rst),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .sda_lvl  (sda_s),
    .start_p  (start_p),
    .stop_p   (stop_p),
    .strap    (strap),
    .rd_data  (rd_data),
    .ptr      (ptr),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .sda_pull (sda_pull)
  );

  psr_reg_bank #(
    .REG_W     (REG_W),
    .PTR_W     (PTR_W),
    .NUM_RW    (NUM_RW),
    .CAPS_WORD (CAPS_WORD)
  ) u_bank (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_addr    (ptr),
    .temp_value (temp_value),
    .rd_data    (rd_data),
    .config_q   (config_q),
    .upper_q    (upper_q),
    .lower_q    (lower_q),
    .critical_q (critical_q)
  );

endmodule

// File: rtl/ptr_serial_regif_chk.sv
module ptr_serial_regif_chk #(
  parameter int REG_W = 16,
  parameter int PTR_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             sda_pull,
  input logic             scl_s,
  input logic             start_p,
  input logic             stop_p,
  input logic             wr_en,
  input logic [PTR_W-1:0] wr_addr,
  input logic [REG_W-1:0] config_q,
  input logic [REG_W-1:0] upper_q,
  input logic [REG_W-1:0] lower_q,
  input logic [REG_W-1:0] critical_q
);

  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!sda_pull && config_q == '0 && upper_q == '0 &&
                    lower_q == '0 && critical_q == '0));

  a_r3_start_releases: assert property (@(posedge clk) disable iff (rst)
    start_p |=> !sda_pull);

  a_r3_stop_releases: assert property (@(posedge clk) disable iff (rst)
    stop_p |=> !sda_pull);

  a_r10_pull_moves_scl_low: assert property (@(posedge clk) disable iff (rst)
    (sda_pull != $past(sda_pull) && !$past(start_p) && !$past(stop_p)) |-> !scl_s);

  a_r6_hold_without_strobe: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(config_q) && $stable(upper_q) &&
                $stable(lower_q) && $stable(critical_q)));

  a_r8_readonly_codes: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_addr == '0 || wr_addr > PTR_W'(4))) |=>
      ($stable(config_q) && $stable(upper_q) &&
       $stable(lower_q) && $stable(critical_q)));

endmodule

bind ptr_serial_regif ptr_serial_regif_chk #(.REG_W(REG_W), .PTR_W(PTR_W)) u_chk (.*);

// File: tb/ptr_serial_regif_tb.sv
module ptr_serial_regif_tb;

  localparam int Q = 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        scl = 1'b1;
  logic        msda = 1'b1;
  logic [2:0]  strap = 3'b101;
  logic [15:0] temp_value = 16'h0C8A;
  logic        sda_pull;
  logic        sda_bus;
  logic [15:0] config_q, upper_q, lower_q, critical_q;

  int          tests = 0;
  int          fails = 0;
  bit          quiet = 1'b0;
  logic [15:0] m_reg [8];
  logic [2:0]  ptr_m = 3'd0;

  always #5 clk = ~clk;

  assign sda_bus = msda & ~sda_pull;

  ptr_serial_regif u_dut (
    .clk        (clk),
    .rst        (rst),
    .scl_in     (scl),
    .sda_in     (sda_bus),
    .sda_pull   (sda_pull),
    .strap      (strap),
    .temp_value (temp_value),
    .config_q   (config_q),
    .upper_q    (upper_q),
    .lower_q    (lower_q),
    .critical_q (critical_q)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_word(input logic [2:0] p);
    if (p == 3'd0) return 16'h0001;
    if (p == 3'd5) return temp_value;
    if (p >= 3'd6) return 16'h0000;
    return m_reg[p];
  endfunction

  function automatic logic [6:0] own_dev();
    return {4'b0011, strap};
  endfunction

  // model comparison on every clock while the bus rests
  always @(negedge clk) begin
    if (quiet && !rst) begin
      chk(config_q == m_reg[1], "R6 config_q", config_q, m_reg[1]);
      chk(upper_q == m_reg[2], "R6 upper_q", upper_q, m_reg[2]);
      chk(lower_q == m_reg[3], "R6 lower_q", lower_q, m_reg[3]);
      chk(critical_q == m_reg[4], "R6 critical_q", critical_q, m_reg[4]);
      chk(!sda_pull, "R10 idle release", sda_pull, 0);
    end
  end

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    msda = 1'b1; wq();
    scl = 1'b1; wq();
    msda = 1'b0; wq();
    scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    msda = 1'b0; wq();
    scl = 1'b1; wq();
    msda = 1'b1; wq();
  endtask

  task automatic xmit(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      msda = b[i]; wq();
      scl = 1'b1; wq(); wq();
      scl = 1'b0; wq();
    end
    msda = 1'b1; wq();
    scl = 1'b1; wq();
    acked = !sda_bus;
    wq();
    scl = 1'b0; wq();
  endtask

  task automatic recv(output logic [7:0] b, input bit give_ack);
    for (int i = 7; i >= 0; i--) begin
      msda = 1'b1; wq();
      scl = 1'b1; wq();
      b[i] = sda_bus;
      wq();
      scl = 1'b0; wq();
    end
    msda = give_ack ? 1'b0 : 1'b1; wq();
    scl = 1'b1; wq(); wq();
    scl = 1'b0; wq();
  endtask

  task automatic finish_tx();
    repeat (4) @(negedge clk);
    quiet = 1'b1;
  endtask

  task automatic wr(input logic [6:0] dev, input logic [7:0] pb, input int nd,
                    input logic [15:0] word, input string tag);
    bit ak;
    bit hit;
    logic [7:0] db;
    hit = (dev == own_dev());
    quiet = 1'b0;
    bus_start();
    xmit({dev, 1'b0}, ak);
    chk(ak == hit, "R2 address ack", ak, hit);
    if (ak) begin
      xmit(pb, ak);
      chk(ak, "R4 pointer ack", ak, 1);
      for (int i = 0; i < nd; i++) begin
        db = (i == 0) ? word[15:8] : (i == 1) ? word[7:0] : 8'(8'hA5 + i);
        xmit(db, ak);
        chk(ak, tag, ak, 1);
      end
    end
    bus_stop();
    if (hit) begin
      ptr_m = pb[2:0];
      if (nd >= 2 && pb[2:0] >= 3'd1 && pb[2:0] <= 3'd4) m_reg[pb[2:0]] = word;
    end
    finish_tx();
  endtask

  task automatic read_words(input int nw, input string tag);
    logic [7:0] hb;
    logic [7:0] lb;
    logic [15:0] ex;
    for (int w = 0; w < nw; w++) begin
      ex = exp_word(ptr_m);
      recv(hb, 1'b1);
      recv(lb, w < nw - 1);
      chk({hb, lb} == ex, tag, {hb, lb}, ex);
    end
  endtask

  task automatic rd(input int nw, input string tag);
    bit ak;
    quiet = 1'b0;
    bus_start();
    xmit({own_dev(), 1'b1}, ak);
    chk(ak, "R2 read address ack", ak, 1);
    if (ak) read_words(nw, tag);
    bus_stop();
    finish_tx();
  endtask

  // pointer write, repeated START, then read
  task automatic ptr_rd(input logic [7:0] pb, input int nw, input string tag);
    bit ak;
    quiet = 1'b0;
    bus_start();
    xmit({own_dev(), 1'b0}, ak);
    chk(ak, "R2 address ack", ak, 1);
    xmit(pb, ak);
    chk(ak, "R4 pointer ack", ak, 1);
    ptr_m = pb[2:0];
    bus_start();
    xmit({own_dev(), 1'b1}, ak);
    chk(ak, "R3 repeated start address ack", ak, 1);
    if (ak) read_words(nw, tag);
    bus_stop();
    finish_tx();
  endtask

  initial begin
    for (int i = 0; i < 8; i++) m_reg[i] = 16'h0000;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(config_q == 0 && upper_q == 0 && lower_q == 0 && critical_q == 0,
        "R1 reset registers", {config_q, upper_q}, 0);
    chk(!sda_pull, "R1 reset release", sda_pull, 0);
    quiet = 1'b1;
    repeat (20) @(negedge clk);

    rd(1, "R1 default pointer reads capability");

    wr(own_dev(), 8'h01, 2, 16'h1234, "R6 config data ack");
    ptr_rd(8'h01, 1, "R6 config readback");
    wr(own_dev(), 8'h02, 2, 16'hBEEF, "R6 upper data ack");
    wr(own_dev(), 8'h03, 2, 16'h00C3, "R6 lower data ack");
    wr(own_dev(), 8'h04, 2, 16'h8001, "R6 critical data ack");
    ptr_rd(8'h02, 1, "R5 upper readback");
    ptr_rd(8'h03, 1, "R5 lower readback");
    ptr_rd(8'h04, 1, "R5 critical readback");

    wr(own_dev(), 8'h00, 2, 16'hFFFF, "R8 capability write ack");
    ptr_rd(8'h00, 1, "R8 capability unchanged");
    wr(own_dev(), 8'h05, 2, 16'h5555, "R8 temperature write ack");
    temp_value = 16'h1F40;
    ptr_rd(8'h05, 1, "R5 temperature follows input");
    wr(own_dev(), 8'h06, 2, 16'h7777, "R8 code 6 write ack");
    ptr_rd(8'h06, 1, "R9 code 6 reads zero");
    wr(own_dev(), 8'h07, 2, 16'h6666, "R8 code 7 write ack");
    ptr_rd(8'h07, 1, "R9 code 7 reads zero");

    wr(own_dev(), 8'hF9, 2, 16'hA00A, "R4 masked pointer data ack");
    ptr_rd(8'h01, 1, "R4 upper pointer bits ignored");

    wr(own_dev(), 8'h02, 1, 16'h9999, "R7 single byte ack");
    ptr_rd(8'h02, 1, "R7 single byte no write");

    wr(own_dev(), 8'h03, 4, 16'h4321, "R11 extra bytes ack");
    ptr_rd(8'h03, 1, "R11 extra bytes ignored");

    wr({4'b0011, 3'b100}, 8'h01, 2, 16'hDEAD, "R2 mismatch");
    wr({4'b0111, 3'b101}, 8'h04, 2, 16'hDEAD, "R2 mismatch base");
    strap = 3'b010;
    repeat (4) @(negedge clk);
    wr({4'b0011, 3'b101}, 8'h04, 2, 16'hCAFE, "R2 old strap");
    wr(own_dev(), 8'h04, 2, 16'h0FF0, "R2 new strap data ack");
    ptr_rd(8'h04, 1, "R2 new strap readback");

    ptr_rd(8'h01, 3, "R9 repeated word read");
    wr(own_dev(), 8'h03, 0, 16'h0000, "R4 pointer only");
    rd(2, "R4 pointer persists across transactions");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL R3 watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule